// File: doc/BRIEF.md
# Memory Protection Key Checker

This block decides whether a memory access may proceed by consulting a small rights register, indexed by the protection key found in the access's translated page entry. Software changes which keys may be read or written by rewriting that register. The page tables stay untouched, so switching protection domains costs one register write. Each access request brings the key, the access kind and the verdict of the ordinary page permission check. One cycle after the request is accepted, the block returns allow, a page permission fault or a key fault.

The rights register holds a pair of bits for each key. One bit disables all data access and the other disables writes. As a build option, a second register with one bit per key can also block instruction fetches from pages carrying that key. Both registers are reached through a plain register port. Reads are combinational and writes land at the clock edge.

Responses pass through a two-state output stage, `RS_EMPTY` and `RS_FULL`. Its transitions are *accept* (`RS_EMPTY` to `RS_FULL` when a request is taken), *reload* (stay in `RS_FULL` when the response drains and a new request is taken at the same edge) and *drain* (`RS_FULL` to `RS_EMPTY` when the response is taken and no request arrives). In `RS_FULL` with no consumer, the stage holds its contents.

Top module: `pkey_guard`

## Requirements
- R1: After reset, both registers read as zero, `rsp_valid` is 0, `req_ready` is 1, and every access whose page permission passes is allowed.
- R2: `KEY_W` of 4 gives 16 keys and 5 gives 32 keys. In the rights register, key k uses bit 2k to disable access and bit 2k+1 to disable writes.
- R3: A read is key-faulted when its key's access-disable bit is set. A write is key-faulted when either its access-disable bit or its write-disable bit is set.
- R4: The two rights bits act independently. A set write-disable bit alone leaves reads of that key allowed, and setting one bit never changes the other.
- R5: Instruction fetches are never blocked by the access-disable or write-disable bits.
- R6: With `XD_EN`=1, bit k of the execute-disable register key-faults fetches with key k. With `XD_EN`=0, writes to that register are ignored and it reads as zero.
- R7: `rsp_code` is 0 for allow, 1 for a page permission fault and 2 for a key fault. When `req_perm_ok` is 0, the code is 1 whatever the key rights are.
- R8: `reg_sel` 0 selects the rights register and 1 selects the execute-disable register, which sits in the low `2**KEY_W` bits. `reg_rdata` follows the register combinationally. A write lands at the clock edge where `reg_we` is 1, and applies to requests accepted at later edges. A request accepted at the same edge still sees the old value.
- R9: A request is accepted on an edge where `req_valid` and `req_ready` are both 1, and its response is valid after that edge. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, the response code stays unchanged.
- R10: `req_kind` encodes 0 for read, 1 for write and 2 for instruction fetch. The value 3 is checked as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the rights register, 1 the execute-disable register |
| reg_wdata | input | 2*2**KEY_W | Register write data |
| reg_rdata | output | 2*2**KEY_W | Selected register contents |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request can be taken |
| req_key | input | KEY_W | Protection key from the page entry |
| req_kind | input | 2 | Access kind |
| req_perm_ok | input | 1 | Ordinary page permission verdict |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_code | output | 2 | Verdict code |

## Verification
The assertions assume that requests and register writes are driven only while `rst_n` is high. They also assume that `req_key`, `req_kind` and `req_perm_ok` are stable at an accepting edge and that `rsp_ready` is a plain level from the consumer. The stimulus meets these assumptions because every input changes only on falling edges, after reset has been released. Kind values cover all four encodings, including the reserved one. Register data is drawn at random across the full width, so both bits of a key pair are exercised in every combination.

// File: rtl/pkey_pkg.sv
package pkey_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_ALTRD = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        CODE_ALLOW = 2'd0,
        CODE_PERM  = 2'd1,
        CODE_KEY   = 2'd2
    } code_e;

    typedef struct packed {
        logic deny_all;
        logic deny_wr;
        logic deny_x;
    } key_rights_t;

endpackage

// File: rtl/pkey_rights_bank.sv
module pkey_rights_bank
    import pkey_pkg::*;
#(
    parameter int KEY_W = 4,
    parameter bit XD_EN = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic                         sel,
    input  logic [2*(1<<KEY_W)-1:0]      wdata,
    output logic [2*(1<<KEY_W)-1:0]      rdata,
    input  logic [KEY_W-1:0]             key,
    output key_rights_t                  rights
);
    localparam int NKEYS    = 1 << KEY_W;
    localparam int RIGHTS_W = 2 * NKEYS;

    logic [RIGHTS_W-1:0] ad_wd_q;
    logic [NKEYS-1:0]    xd_q;
    logic [KEY_W:0]      pair_base;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ad_wd_q <= '0;
        end else if (we && !sel) begin
            ad_wd_q <= wdata;
        end
    end

    generate
        if (XD_EN) begin : g_xd
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    xd_q <= '0;
                end else if (we && sel) begin
                    xd_q <= wdata[NKEYS-1:0];
                end
            end
        end else begin : g_no_xd
            assign xd_q = '0;
        end
    endgenerate

    assign pair_base       = {key, 1'b0};
    assign rights.deny_all = ad_wd_q[pair_base];
    assign rights.deny_wr  = ad_wd_q[pair_base + 1'b1];
    assign rights.deny_x   = xd_q[key];

    always_comb begin
        if (sel) begin
            rdata = {{(RIGHTS_W-NKEYS){1'b0}}, xd_q};
        end else begin
            rdata = ad_wd_q;
        end
    end

    // R8: a rights write is visible through the read path one edge later
    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !sel && !sel) |=> (!sel || rdata == $past(wdata)));

endmodule

// File: rtl/pkey_decide.sv
module pkey_decide
    import pkey_pkg::*;
(
    input  logic [1:0]   kind,
    input  logic         perm_ok,
    input  key_rights_t  rights,
    output logic [1:0]   code
);
    kind_e k;
    logic  key_block;

    assign k = kind_e'(kind);

    always_comb begin
        unique case (k)
            KIND_WRITE: key_block = rights.deny_all | rights.deny_wr;
            KIND_FETCH: key_block = rights.deny_x;
            KIND_READ,
            KIND_ALTRD: key_block = rights.deny_all;
            default:    key_block = rights.deny_all;
        endcase
    end

    always_comb begin
        if (!perm_ok) begin
            code = CODE_PERM;
        end else if (key_block) begin
            code = CODE_KEY;
        end else begin
            code = CODE_ALLOW;
        end
    end

endmodule

// File: rtl/pkey_resp_fsm.sv
module pkey_resp_fsm
    import pkey_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  code_in,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [1:0]  rsp_code
);
    typedef enum logic {
        RS_EMPTY = 1'b0,
        RS_FULL  = 1'b1
    } rs_state_e;

    rs_state_e state_q, state_d;
    logic [1:0] code_q;
    logic       take;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_EMPTY;
            code_q  <= CODE_ALLOW;
        end else begin
            state_q <= state_d;
            if (take) begin
                code_q <= code_in;
            end
        end
    end

    always_comb begin
        state_d   = state_q;
        req_ready = 1'b1;
        unique case (state_q)
            RS_EMPTY: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    state_d = RS_FULL;          // accept
                end
            end
            RS_FULL: begin
                req_ready = rsp_ready;
                if (rsp_ready && !req_valid) begin
                    state_d = RS_EMPTY;         // drain
                end else begin
                    state_d = RS_FULL;          // reload or hold
                end
            end
            default: begin
                state_d   = RS_EMPTY;
                req_ready = 1'b0;
            end
        endcase
        take = req_valid && req_ready;
    end

    assign rsp_valid = (state_q == RS_FULL);
    assign rsp_code  = code_q;

    // R9: a stalled response keeps its code and stays valid
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code)));

    // R9: an accepted request always produces a response after the edge
    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

endmodule

// File: rtl/pkey_guard.sv
module pkey_guard
    import pkey_pkg::*;
#(
    parameter int KEY_W = 4,
    parameter bit XD_EN = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic                     reg_sel,
    input  logic [2*(1<<KEY_W)-1:0]  reg_wdata,
    output logic [2*(1<<KEY_W)-1:0]  reg_rdata,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [KEY_W-1:0]         req_key,
    input  logic [1:0]               req_kind,
    input  logic                     req_perm_ok,
    output logic                     rsp_valid,
    input  logic                     rsp_ready,
    output logic [1:0]               rsp_code
);
    key_rights_t rights;
    logic [1:0]  verdict;

    pkey_rights_bank #(.KEY_W(KEY_W), .XD_EN(XD_EN)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .key    (req_key),
        .rights (rights)
    );

    pkey_decide u_decide (
        .kind    (req_kind),
        .perm_ok (req_perm_ok),
        .rights  (rights),
        .code    (verdict)
    );

    pkey_resp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .code_in   (verdict),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_code  (rsp_code)
    );

    // R7: a failed page permission wins over any key verdict
    p_perm_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_perm_ok) |=> (rsp_code == CODE_PERM));

    // R7: the reserved code value never appears
    p_code_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_code != 2'd3));

    // R5: fetches with passing permission and no execute block are allowed
    p_fetch_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_perm_ok && req_kind == KIND_FETCH && !rights.deny_x)
        |=> (rsp_code == CODE_ALLOW));

    // R3: a set access-disable bit faults any data access with passing permission
    p_deny_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_perm_ok && req_kind != KIND_FETCH && rights.deny_all)
        |=> (rsp_code == CODE_KEY));

endmodule

// File: tb/pkey_guard_test.sv
`timescale 1ns/1ps
module pkey_guard_test;
    localparam int KW = 4;
    localparam int NK = 1 << KW;
    localparam int RW = 2 * NK;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0, reg_sel = 1'b0;
    logic [RW-1:0] reg_wdata = '0, reg_rdata;
    logic req_valid = 1'b0, req_ready, req_perm_ok = 1'b1;
    logic [KW-1:0] req_key = '0;
    logic [1:0] req_kind = 2'd0;
    logic rsp_valid, rsp_ready = 1'b1;
    logic [1:0] rsp_code;

    int errors = 0, checks = 0;
    bit done = 1'b0;
    logic [RW-1:0] sh_r = '0;
    logic [NK-1:0] sh_x = '0;

    always #2.5 clk = ~clk;

    pkey_guard #(.KEY_W(KW), .XD_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_key(req_key), .req_kind(req_kind),
        .req_perm_ok(req_perm_ok), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_code(rsp_code)
    );

    function automatic int expect_code(int key, int kind, bit perm);
        bit ad, wd;
        if (!perm) return 1;
        ad = sh_r[2*key];
        wd = sh_r[2*key+1];
        if (kind == 2) return sh_x[key] ? 2 : 0;
        if (kind == 1) return (ad || wd) ? 2 : 0;
        return ad ? 2 : 0;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(bit sel, logic [RW-1:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        if (sel) sh_x = data[NK-1:0]; else sh_r = data;
    endtask

    task automatic rd(bit sel, string req);
        logic [RW-1:0] e;
        @(negedge clk);
        reg_sel = sel;
        #0.5;
        e = sel ? {{(RW-NK){1'b0}}, sh_x} : sh_r;
        check(reg_rdata == e, req, reg_rdata, e);
    endtask

    task automatic acc(int key, int kind, bit perm, string req);
        int e;
        @(negedge clk);
        req_valid = 1'b1; req_key = KW'(key); req_kind = 2'(kind); req_perm_ok = perm;
        e = expect_code(key, kind, perm);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, req, rsp_valid, 1);
        check(rsp_code == 2'(e), req, rsp_code, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        #0.5;
        check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        rd(1'b0, "R1 rights zero");
        rd(1'b1, "R1 xd zero");
        for (int k = 0; k < NK; k += 5) acc(k, k % 4, 1'b1, "R1 allowed");

        // R2: key 15 write-disable at bit 31; key 14 untouched
        wr(1'b0, RW'(1) << 31);
        rd(1'b0, "R2 readback");
        acc(15, 0, 1'b1, "R4 read with wd");
        acc(15, 1, 1'b1, "R2 write key15");
        acc(14, 1, 1'b1, "R2 key14 free");
        // R3: access-disable for key 2 (bit 4)
        wr(1'b0, RW'(1) << 4);
        acc(2, 0, 1'b1, "R3 read ad");
        acc(2, 1, 1'b1, "R3 write ad");
        acc(2, 2, 1'b1, "R5 fetch ad");
        // R10: kind 3 behaves as read
        acc(2, 3, 1'b1, "R10 alt ad");
        wr(1'b0, RW'(1) << 5);
        acc(2, 3, 1'b1, "R10 alt wd");
        acc(2, 2, 1'b1, "R5 fetch wd");
        // R7: permission priority
        acc(2, 1, 1'b0, "R7 perm first");
        // R6: execute disable key 2
        wr(1'b1, RW'(1) << 2);
        rd(1'b1, "R6 xd readback");
        acc(2, 2, 1'b1, "R6 fetch xd");
        acc(3, 2, 1'b1, "R6 other key");
        acc(2, 0, 1'b1, "R6 read unaffected");

        // R8: write and request at same edge
        wr(1'b0, '0);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = RW'(1) << 6;
        req_valid = 1'b1; req_key = 4'd3; req_kind = 2'd0; req_perm_ok = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0; req_valid = 1'b0; sh_r = RW'(1) << 6;
        check(rsp_code == 2'd0, "R8 old value", rsp_code, 0);
        acc(3, 0, 1'b1, "R8 new value");

        // R9: stall holds the response; queued request lands after release
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_key = 4'd3; req_kind = 2'd1; req_perm_ok = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_key = 4'd4; req_kind = 2'd0;
        for (int i = 0; i < 3; i++) begin
            check(rsp_valid == 1'b1, "R9 held valid", rsp_valid, 1);
            check(rsp_code == 2'd2, "R9 held code", rsp_code, 2);
            check(req_ready == 1'b0, "R9 ready low", req_ready, 0);
            @(negedge clk);
        end
        rsp_ready = 1'b1;
        #0.5;
        check(req_ready == 1'b1, "R9 ready follows", req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1 && rsp_code == 2'd0, "R9 reload", rsp_code, 0);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R9 drain", rsp_valid, 0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int r;
            r = $urandom % 5;
            if (r == 0) begin
                wr(1'($urandom), {$urandom, $urandom});
            end else if (r == 1) begin
                rd(1'($urandom), "R8 random read");
            end else begin
                int kind;
                kind = $urandom % 4;
                acc($urandom % NK, kind, ($urandom % 6) != 0,
                    kind == 2 ? "R5 random fetch" : "R3 random data");
            end
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule